// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block computes a three-tap finite impulse response filter over a sample stream that arrives three samples at a time. Each clock cycle with the input strobe high, it takes three consecutive samples on three parallel lanes. It returns the three matching filter outputs on three parallel output lanes one clock later. The lanes carry samples in time order: lane 0 holds x(3k), lane 1 holds x(3k+1) and lane 2 holds x(3k+2). Because of this, the stream moves at three samples per clock. The logic between registers stays at one multiply and a short adder tree.

Each output lane has its own multiply-add network. The taps that reach back before the current block come from block-delay registers. These registers keep the last two samples of the previous accepted block. One tick of these registers equals three sample periods. Coefficients are plain inputs, sampled in the same cycle as the block that uses them. Samples and coefficients are 16-bit signed values. Outputs are 34-bit signed values, which is wide enough that no legal input combination can overflow.

Top module: `blkfir3_top`

## Requirements
- R1: When in_vld is high, out_y0 in the next cycle equals a*x(3k) + b*x(3k-1) + c*x(3k-2), where a, b, c are coef_a, coef_b, coef_c and x(3k) is in_x0.
- R2: When in_vld is high, out_y1 in the next cycle equals a*x(3k+1) + b*x(3k) + c*x(3k-1), where x(3k+1) is in_x1.
- R3: When in_vld is high, out_y2 in the next cycle equals a*x(3k+2) + b*x(3k+1) + c*x(3k), where x(3k+2) is in_x2.
- R4: x(3k-1) and x(3k-2) are the in_x2 and in_x1 values of the most recent earlier cycle in which in_vld was high.
- R5: Cycles with in_vld low leave the stored previous-block samples unchanged, whatever the sample inputs carry, so the filtered stream continues across gaps.
- R6: out_vld is high exactly in the cycle after a cycle with in_vld high, giving one clock of latency.
- R7: After a cycle with in_vld low, out_y0, out_y1 and out_y2 keep their previous values.
- R8: While rst is high, and in the first cycle after it, out_vld is 0 and all outputs are 0. The stored previous-block samples are cleared to zero, so the first block after reset sees zero history.
- R9: Products and sums are exact signed values. Full-scale inputs such as -32768 for every sample and coefficient give 3*2^30 with no wrap.
- R10: A coefficient change takes effect in the very block accepted in the same cycle, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input block strobe |
| in_x0 | input | 16 | Sample x(3k), signed |
| in_x1 | input | 16 | Sample x(3k+1), signed |
| in_x2 | input | 16 | Sample x(3k+2), signed |
| coef_a | input | 16 | Coefficient a, applied to the current sample, signed |
| coef_b | input | 16 | Coefficient b, applied to one sample back, signed |
| coef_c | input | 16 | Coefficient c, applied to two samples back, signed |
| out_vld | output | 1 | Output block valid |
| out_y0 | output | 34 | Output y(3k), signed |
| out_y1 | output | 34 | Output y(3k+1), signed |
| out_y2 | output | 34 | Output y(3k+2), signed |

## Verification
The only internal state is the pair of previous-block samples. If that pair is wrong, the fault shows at the ports on the next accepted block: out_y0 is off through its b and c terms, and out_y1 is off through its c term, while out_y2 stays correct. A fault in the store therefore appears one block later, and only on the two lower lanes. The bench uses non-zero b and c, inserts idle cycles that carry junk samples, and compares every lane against a filter that processes one sample at a time. This catches a wrong tap lane, a swapped history pair, or history that moves during idle cycles within one block.

// File: rtl/blkfir_pkg.sv
package blkfir_pkg;

    localparam int SMP_W  = 16;
    localparam int COEF_W = 16;
    localparam int LANES  = 3;
    localparam int TAPS   = 3;
    localparam int HIST   = TAPS - 1;
    localparam int ACC_W  = SMP_W + COEF_W + $clog2(TAPS);
    localparam int EXT_N  = HIST + LANES;

    typedef logic signed [SMP_W-1:0]  sample_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef sample_t [LANES-1:0] blk_t;
    typedef sample_t [HIST-1:0]  hist_t;
    typedef sample_t [TAPS-1:0]  taps_t;
    typedef coef_t   [TAPS-1:0]  coefs_t;
    typedef acc_t    [LANES-1:0] acc_blk_t;

    typedef struct packed {
        logic     vld;
        acc_blk_t y;
    } out_bundle_t;

    function automatic acc_t mul_wide(input sample_t s, input coef_t c);
        acc_t sw;
        acc_t cw;
        sw = ACC_W'(s);
        cw = ACC_W'(c);
        return sw * cw;
    endfunction

endpackage

// File: rtl/blkfir_history.sv
module blkfir_history
    import blkfir_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  hist_t tail_i,
    output hist_t hist_o
);

    hist_t hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (load_i) begin
            hist_q <= tail_i;
        end
    end

    assign hist_o = hist_q;

    AST_HIST_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_i |=> hist_o == $past(tail_i)); // R4

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(hist_o)); // R5

endmodule

// File: rtl/blkfir_lane.sv
module blkfir_lane
    import blkfir_pkg::*;
(
    input  taps_t  taps_i,
    input  coefs_t coefs_i,
    output acc_t   sum_o
);

    acc_t [TAPS-1:0] prod;

    genvar t;
    generate
        for (t = 0; t < TAPS; t++) begin : g_mul
            assign prod[t] = mul_wide(taps_i[t], coefs_i[t]);
        end
    endgenerate

    always_comb begin
        sum_o = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum_o = sum_o + prod[t];
        end
    end

endmodule

// File: rtl/blkfir_outreg.sv
module blkfir_outreg
    import blkfir_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        vld_i,
    input  acc_blk_t    y_i,
    output out_bundle_t q_o
);

    out_bundle_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= vld_i;
            if (vld_i) begin
                q.y <= y_i;
            end
        end
    end

    assign q_o = q;

    AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> q_o.vld); // R6

    AST_VLD_DROP: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !q_o.vld); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(q_o.y)); // R7

endmodule

// File: rtl/blkfir3_top.sv
module blkfir3_top
    import blkfir_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [SMP_W-1:0] in_x0,
    input  logic signed [SMP_W-1:0] in_x1,
    input  logic signed [SMP_W-1:0] in_x2,
    input  logic signed [COEF_W-1:0] coef_a,
    input  logic signed [COEF_W-1:0] coef_b,
    input  logic signed [COEF_W-1:0] coef_c,
    output logic                    out_vld,
    output logic signed [ACC_W-1:0] out_y0,
    output logic signed [ACC_W-1:0] out_y1,
    output logic signed [ACC_W-1:0] out_y2
);

    blk_t        x_blk;
    coefs_t      coefs;
    hist_t       tail;
    hist_t       hist;
    sample_t     ext [EXT_N];
    acc_blk_t    sums;
    out_bundle_t ob;

    assign x_blk[0] = in_x0;
    assign x_blk[1] = in_x1;
    assign x_blk[2] = in_x2;

    // coefficient index t multiplies the sample t periods back
    assign coefs[0] = coef_a;
    assign coefs[1] = coef_b;
    assign coefs[2] = coef_c;

    genvar j;
    generate
        // the newest HIST samples of a block become the history of the next
        for (j = 0; j < HIST; j++) begin : g_tail
            assign tail[j]   = x_blk[LANES-HIST+j];
            assign ext[j]    = hist[j];
        end
        for (j = 0; j < LANES; j++) begin : g_ext
            assign ext[HIST+j] = x_blk[j];
        end
    endgenerate

    blkfir_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .load_i (in_vld),
        .tail_i (tail),
        .hist_o (hist)
    );

    genvar l, t;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            taps_t taps;
            for (t = 0; t < TAPS; t++) begin : g_tap
                assign taps[t] = ext[HIST+l-t];
            end
            blkfir_lane u_lane (
                .taps_i  (taps),
                .coefs_i (coefs),
                .sum_o   (sums[l])
            );
        end
    endgenerate

    blkfir_outreg u_out (
        .clk   (clk),
        .rst   (rst),
        .vld_i (in_vld),
        .y_i   (sums),
        .q_o   (ob)
    );

    assign out_vld = ob.vld;
    assign out_y0  = ob.y[0];
    assign out_y1  = ob.y[1];
    assign out_y2  = ob.y[2];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_vld && out_y0 == '0 && out_y1 == '0 && out_y2 == '0)); // R8

endmodule

// File: tb/blkfir3_top_test.sv
`timescale 1ns/1ps
module blkfir3_top_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic signed [15:0] in_x0 = '0, in_x1 = '0, in_x2 = '0;
    logic signed [15:0] coef_a = '0, coef_b = '0, coef_c = '0;
    logic out_vld;
    logic signed [33:0] out_y0, out_y1, out_y2;

    int n_checks = 0;
    int n_fail   = 0;

    // serial reference state: previous two samples of the stream
    longint m1 = 0;
    longint m2 = 0;
    longint last_y [3] = '{0, 0, 0};

    always #4 clk = ~clk;

    blkfir3_top uut (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .out_vld(out_vld), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ydut(input int lane);
        case (lane)
            0: return longint'(out_y0);
            1: return longint'(out_y1);
            default: return longint'(out_y2);
        endcase
    endfunction

    // drive one block at a negedge, check at the next negedge
    task automatic send_block(input int s0, input int s1, input int s2, input string tag);
        longint xs [3];
        longint e [3];
        xs[0] = s0; xs[1] = s1; xs[2] = s2;
        in_x0 = 16'(s0); in_x1 = 16'(s1); in_x2 = 16'(s2);
        in_vld = 1'b1;
        for (int i = 0; i < 3; i++) begin
            e[i] = longint'(coef_a) * xs[i] + longint'(coef_b) * m1 + longint'(coef_c) * m2;
            m2 = m1;
            m1 = xs[i];
        end
        @(negedge clk);
        in_vld = 1'b0;
        check({tag, " R6 out_vld"}, longint'(out_vld), 1);
        check({tag, " R1 y0"}, ydut(0), e[0]);
        check({tag, " R2 y1"}, ydut(1), e[1]);
        check({tag, " R3 y2"}, ydut(2), e[2]);
        for (int i = 0; i < 3; i++) last_y[i] = e[i];
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m1 = 0; m2 = 0;
        check("R8 out_vld in reset", longint'(out_vld), 0);
        @(negedge clk);
        check("R8 out_vld after reset", longint'(out_vld), 0);
        check("R8 y0 after reset", ydut(0), 0);
        check("R8 y2 after reset", ydut(2), 0);
        for (int i = 0; i < 3; i++) last_y[i] = 0;
    endtask

    task automatic t_basic();
        coef_a = 16'sd3; coef_b = -16'sd5; coef_c = 16'sd7;
        send_block(1, 2, 3, "basic first block R8 R4");
        send_block(10, -20, 30, "basic R4");
        send_block(-4, 100, 9, "basic R4");
    endtask

    task automatic t_idle();
        for (int k = 0; k < 3; k++) begin
            in_vld = 1'b0;
            in_x0 = 16'sh7abc; in_x1 = -16'sd999; in_x2 = 16'sd1234;
            @(negedge clk);
            check("R6 idle out_vld", longint'(out_vld), 0);
            for (int i = 0; i < 3; i++) check("R7 idle hold", ydut(i), last_y[i]);
        end
        send_block(5, 6, 7, "after gap R5");
    endtask

    task automatic t_extreme();
        coef_a = -16'sd32768; coef_b = -16'sd32768; coef_c = -16'sd32768;
        send_block(-32768, -32768, -32768, "fullscale R9");
        send_block(-32768, -32768, -32768, "fullscale R9");
        coef_a = 16'sd32767; coef_b = -16'sd32768; coef_c = 16'sd32767;
        send_block(32767, -32768, 32767, "mixed R9");
    endtask

    task automatic t_coef_change();
        coef_a = 16'sd1; coef_b = 16'sd0; coef_c = 16'sd0;
        send_block(11, 22, 33, "coef pass R10");
        coef_a = 16'sd0; coef_b = 16'sd0; coef_c = 16'sd1;
        send_block(44, 55, 66, "coef delay2 R10 R4");
        coef_a = 16'sd0; coef_b = 16'sd1; coef_c = 16'sd0;
        send_block(77, 88, 99, "coef delay1 R10 R4");
    endtask

    task automatic t_random();
        for (int k = 0; k < 40; k++) begin
            coef_a = 16'($urandom); coef_b = 16'($urandom); coef_c = 16'($urandom);
            send_block(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                       int'($signed(16'($urandom))), "random R1 R2 R3");
            if (k % 7 == 3) begin
                in_x0 = 16'($urandom); in_x1 = 16'($urandom); in_x2 = 16'($urandom);
                @(negedge clk);
                check("R7 random gap", ydut(1), last_y[1]);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_idle();
        t_extreme();
        t_coef_change();
        t_random();
        t_reset();
        coef_a = 16'sd2; coef_b = 16'sd4; coef_c = 16'sd8;
        send_block(1, 1, 1, "second reset R8");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule